// File: doc/BRIEF.md
# Half-Width Float Multiplier (1/6/9 Layout)

This block multiplies two 16-bit floating-point words and delivers a 16-bit product. Each word has a sign bit at bit 15, a 6-bit biased exponent in bits 14:9 (bias 31) and a 9-bit stored fraction in bits 8:0. A leading one is restored in front of each fraction to form 10-bit significands. The significands are multiplied into a 20-bit product by an array of shift-and-add rows, with no behavioural multiply operator. The product is then normalized, rounded to nearest with ties to even, and packed.

The exponent is carried two bits wider than its field. A result that grows past the largest finite exponent therefore saturates to infinity and raises an overflow flag instead of wrapping. A result that falls to a biased exponent of zero or below flushes to a signed zero and raises an underflow flag. Exponent field zero is read as zero; fractions there are ignored. Exponent field all ones is read as infinity when the fraction is zero and as NaN otherwise. The result and both flags are registered and are cleared by a synchronous active-high reset.

Top module: `fp16c_mul`

## Requirements
- R1: With both inputs finite and non-zero, z is the correctly rounded product: exponent field ex+ey-31 (after normalization) and the product fraction packed in bits 8:0 (1.0 is 0x3E00, 2.0 is 0x4000, 3.0 is 0x4100).
- R2: The sign bit z[15] of every non-NaN result equals x[15] XOR y[15], including zero and infinity results.
- R3: When the significand product is 2.0 or more, it is shifted right one place and the exponent grows by one (1.5 x 1.5 = 0x4040).
- R4: The fraction is rounded to nearest on the discarded bits; an exact half rounds to the even fraction.
- R5: A rounding carry out of the fraction gives fraction 0 and raises the exponent by one more.
- R6: A final biased exponent of 63 or more gives infinity (exponent field 0x3F, fraction 0) with the result sign and ovf=1; the largest finite value 0x7DFF squared gives 0x7E00. A final exponent of 62 stays finite.
- R7: A final biased exponent of 0 or less gives a zero with the result sign and unf=1; a final exponent of 1 stays finite.
- R8: An operand with exponent field 0 is zero whatever its fraction; a product with a zero operand and no infinity or NaN is a signed zero with both flags low.
- R9: A NaN operand, or infinity times zero, gives the canonical NaN 0x7F00 with both flags low.
- R10: Infinity times a non-zero non-NaN operand gives infinity (0x7E00 or 0xFE00) with the XOR sign and both flags low.
- R11: z, ovf and unf change only at a rising clock edge, showing the product of the inputs present at that edge; while rst is high at an edge they become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| z | output | 16 | Registered product |
| ovf | output | 1 | Registered overflow flag for the product in z |
| unf | output | 1 | Registered underflow flag for the product in z |

## Verification
Every result is due exactly one rising edge after its operands are applied, because the arithmetic is combinational and only the output register lies between operands and ports. The bench drives operands on a falling edge and samples z and the flags at the next falling edge, half a period after the capturing edge. A directed step changes operands and samples again before the next rising edge to show the old result is still held. Another holds rst high across one edge and confirms the outputs clear and then return to the held product one edge after rst falls.

// File: rtl/fp16c_pkg.sv
package fp16c_pkg;

  localparam int DEF_EXP_W = 6;
  localparam int DEF_MAN_W = 9;
  localparam int DEF_BIAS  = 31;

  // operand classes after unpacking
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_t;

endpackage

// File: rtl/fp16c_unpack.sv
module fp16c_unpack
  import fp16c_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic [W-1:0]     word,
  output logic             sign,
  output logic [EXP_W-1:0] expo,
  output logic [SIG_W-1:0] sig,
  output fcls_t            cls
);

  logic [MAN_W-1:0] frac;

  assign sign = word[W-1];
  assign expo = word[W-2 -: EXP_W];
  assign frac = word[MAN_W-1:0];
  assign sig  = {1'b1, frac};

  always_comb begin
    if (expo == '0)
      cls = CLS_ZERO;              // subnormals flush here
    else if (expo == '1)
      cls = (frac == '0) ? CLS_INF : CLS_NAN;
    else
      cls = CLS_NORM;
  end

endmodule

// File: rtl/fp16c_sigmul.sv
module fp16c_sigmul #(
  parameter int SIG_W = 10,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0]  a,
  input  logic [SIG_W-1:0]  b,
  output logic [PROD_W-1:0] prod
);

  // one shifted row of a per bit of b, summed down a chain
  logic [PROD_W-1:0] acc [SIG_W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < SIG_W; i++) begin : g_row
    logic [PROD_W-1:0] row;
    assign row        = b[i] ? (PROD_W'(a) << i) : '0;
    assign acc[i + 1] = acc[i] + row;
  end

  assign prod = acc[SIG_W];

endmodule

// File: rtl/fp16c_round.sv
module fp16c_round #(
  parameter int EXP_W = 6,
  parameter int MAN_W = 9,
  parameter int BIAS  = 31,
  localparam int W      = 1 + EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int EW     = EXP_W + 2,
  localparam int EXP_SAT = (1 << EXP_W) - 1
) (
  input  logic              sign,
  input  logic [EXP_W-1:0]  ex,
  input  logic [EXP_W-1:0]  ey,
  input  logic [PROD_W-1:0] prod,
  output logic [W-1:0]      word,
  output logic              ovf,
  output logic              unf
);

  logic                 hi;
  logic [PROD_W-2:0]    shifted;
  logic [MAN_W-1:0]     mant;
  logic                 guard;
  logic                 sticky;
  logic                 rnd;
  logic [MAN_W:0]       mant_r;
  logic                 carry;
  logic signed [EW-1:0] exp_sum;
  logic signed [EW-1:0] exp_f;

  // widened exponent so that the sum cannot wrap
  assign exp_sum = $signed({2'b00, ex}) + $signed({2'b00, ey}) - EW'(BIAS);

  assign hi      = prod[PROD_W-1];
  assign shifted = hi ? prod[PROD_W-2:0] : {prod[PROD_W-3:0], 1'b0};
  assign mant    = shifted[PROD_W-2 -: MAN_W];
  assign guard   = shifted[PROD_W-2-MAN_W];
  assign sticky  = |shifted[PROD_W-3-MAN_W:0];

  // nearest, ties to even
  assign rnd    = guard & (sticky | mant[0]);
  assign mant_r = {1'b0, mant} + (MAN_W+1)'(rnd);
  assign carry  = mant_r[MAN_W];

  assign exp_f = exp_sum + EW'(hi) + EW'(carry);

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (int'(exp_f) >= EXP_SAT) begin
      ovf  = 1'b1;
      word = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (int'(exp_f) <= 0) begin
      unf  = 1'b1;
      word = {sign, {(W-1){1'b0}}};
    end else begin
      word = {sign, exp_f[EXP_W-1:0], mant_r[MAN_W-1:0]};
    end
  end

endmodule

// File: rtl/fp16c_mul.sv
module fp16c_mul
  import fp16c_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  parameter int BIAS  = DEF_BIAS,
  localparam int W      = 1 + EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z,
  output logic         ovf,
  output logic         unf
);

  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic              sx, sy, sz;
  logic [EXP_W-1:0]  ex, ey;
  logic [SIG_W-1:0]  ax, ay;
  fcls_t             cx, cy;
  logic [PROD_W-1:0] prod;
  logic [W-1:0]      num_word;
  logic              num_ovf, num_unf;
  logic [W-1:0]      z_d;
  logic              ovf_d, unf_d;
  logic              is_nan, is_inf, is_zero;

  fp16c_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unx (
    .word(x), .sign(sx), .expo(ex), .sig(ax), .cls(cx)
  );

  fp16c_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_uny (
    .word(y), .sign(sy), .expo(ey), .sig(ay), .cls(cy)
  );

  fp16c_sigmul #(.SIG_W(SIG_W)) u_sig (
    .a(ax), .b(ay), .prod(prod)
  );

  assign sz = sx ^ sy;

  fp16c_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_rnd (
    .sign(sz), .ex(ex), .ey(ey), .prod(prod),
    .word(num_word), .ovf(num_ovf), .unf(num_unf)
  );

  assign is_nan  = (cx == CLS_NAN) || (cy == CLS_NAN) ||
                   ((cx == CLS_INF) && (cy == CLS_ZERO)) ||
                   ((cx == CLS_ZERO) && (cy == CLS_INF));
  assign is_inf  = (cx == CLS_INF) || (cy == CLS_INF);
  assign is_zero = (cx == CLS_ZERO) || (cy == CLS_ZERO);

  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (is_nan)
      z_d = QNAN;
    else if (is_inf)
      z_d = {sz, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (is_zero)
      z_d = {sz, {(W-1){1'b0}}};
    else begin
      z_d   = num_word;
      ovf_d = num_ovf;
      unf_d = num_unf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z   <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      z   <= z_d;
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (z == '0 && !ovf && !unf)); // R11
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) !(ovf && unf)); // R6
  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst) ovf |-> (z[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}})); // R6
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst) unf |-> (z[W-2:0] == '0)); // R7
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst) ((z[W-2 -: EXP_W] == '1) && (z[MAN_W-1:0] != '0)) |-> (z == QNAN)); // R9
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && z != QNAN) |-> (z[W-1] == ($past(x[W-1]) ^ $past(y[W-1])))); // R2

endmodule

// File: tb/fp16c_mul_test.sv
module fp16c_mul_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // {req[3:0], x, y, expected z, ovf, unf}
  localparam logic [53:0] VEC [NV] = '{
    {4'd1,  16'h3E00, 16'h3E00, 16'h3E00, 1'b0, 1'b0}, // R1 1*1
    {4'd1,  16'h4000, 16'h3F00, 16'h4100, 1'b0, 1'b0}, // R1 2*1.5
    {4'd2,  16'hBE00, 16'h4000, 16'hC000, 1'b0, 1'b0}, // R2 -1*2
    {4'd2,  16'hC100, 16'hC000, 16'h4300, 1'b0, 1'b0}, // R2 -3*-2
    {4'd3,  16'h3F00, 16'h3F00, 16'h4040, 1'b0, 1'b0}, // R3 1.5*1.5
    {4'd4,  16'h3E01, 16'h3F00, 16'h3F02, 1'b0, 1'b0}, // R4 half, odd -> up
    {4'd4,  16'h3E03, 16'h3F00, 16'h3F04, 1'b0, 1'b0}, // R4 half, even -> stay
    {4'd5,  16'h3FFE, 16'h3E01, 16'h4000, 1'b0, 1'b0}, // R5 carry out
    {4'd6,  16'h7DFF, 16'h7DFF, 16'h7E00, 1'b1, 1'b0}, // R6 max squared
    {4'd6,  16'h5E00, 16'h5E00, 16'h7E00, 1'b1, 1'b0}, // R6 exponent 63
    {4'd6,  16'h7D00, 16'h3F00, 16'h7E00, 1'b1, 1'b0}, // R6 via normalization
    {4'd6,  16'h5C00, 16'h5E00, 16'h7C00, 1'b0, 1'b0}, // R6 exponent 62 finite
    {4'd7,  16'h8200, 16'h0200, 16'h8000, 1'b0, 1'b1}, // R7 negative flush
    {4'd7,  16'h2000, 16'h2000, 16'h0200, 1'b0, 1'b0}, // R7 exponent 1 finite
    {4'd7,  16'h2000, 16'h1E00, 16'h0000, 1'b0, 1'b1}, // R7 exponent 0
    {4'd8,  16'h0000, 16'hC100, 16'h8000, 1'b0, 1'b0}, // R8 signed zero
    {4'd8,  16'h0005, 16'h3E00, 16'h0000, 1'b0, 1'b0}, // R8 subnormal flush
    {4'd9,  16'h7E01, 16'h3E00, 16'h7F00, 1'b0, 1'b0}, // R9 NaN in
    {4'd9,  16'hFE00, 16'h0000, 16'h7F00, 1'b0, 1'b0}, // R9 inf*0
    {4'd10, 16'hFE00, 16'h4000, 16'hFE00, 1'b0, 1'b0}, // R10 -inf*2
    {4'd10, 16'h7E00, 16'hFE00, 16'hFE00, 1'b0, 1'b0}, // R10 inf*-inf
    {4'd9,  16'h0000, 16'h7E00, 16'h7F00, 1'b0, 1'b0}  // R9 0*inf
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x = '0;
  logic [15:0] y = '0;
  logic [15:0] z;
  logic        ovf, unf;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  fp16c_mul uut (
    .clk(clk), .rst(rst), .x(x), .y(y), .z(z), .ovf(ovf), .unf(unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int req, input logic [15:0] ez,
                     input logic eo, input logic eu);
    checks++;
    if (z !== ez || ovf !== eo || unf !== eu) begin
      errors++;
      $display("FAIL R%0d: z=%h ovf=%b unf=%b expected z=%h ovf=%b unf=%b",
               req, z, ovf, unf, ez, eo, eu);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(11, 16'h0000, 1'b0, 1'b0);            // R11 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      x = VEC[i][49:34];
      y = VEC[i][33:18];
      @(negedge clk);
      chk(int'(VEC[i][53:50]), VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end

    // R11: output holds until the next rising edge
    @(negedge clk);
    x = 16'h7DFF; y = 16'h7DFF;
    @(negedge clk);
    chk(11, 16'h7E00, 1'b1, 1'b0);
    x = 16'h3E00; y = 16'h3E00;
    #1;
    chk(11, 16'h7E00, 1'b1, 1'b0);            // R11 old product still held
    @(negedge clk);
    chk(11, 16'h3E00, 1'b0, 1'b0);            // R11 new product one edge later

    // R11: synchronous reset clears, then the held inputs return
    x = 16'h7DFF; y = 16'h7DFF;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(11, 16'h0000, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk(11, 16'h7E00, 1'b1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule